// File: doc/BRIEF.md
# Operand Forwarding Unit

This block decides where each operand of the instruction in the execute stage of a five-stage integer pipeline comes from. An operand can be the register value read during decode, the result waiting in the execute/memory pipeline register, or the value in the memory/write-back pipeline register. That last value is either an ALU result or load data. The block drives one select for the first ALU input, one for the second ALU input, and one for the data operand of a store. The datapath multiplexers use these selects. The register file and the ALU are outside the block.

The block follows instructions on its own. Each cycle the decode stage presents one instruction slot: a valid bit, two source register numbers, a destination register number, a write enable, an immediate-operand flag and a store flag. The block registers these fields into an execute-stage copy. It then shifts the destination information through two producer stages that match the execute/memory and memory/write-back registers. The selects are decoded from the execute-stage copy and the two producer stages.

The register file writes in the first half of the cycle and is read in the second half. An instruction three slots behind its producer therefore reads the new value directly, so only distances one and two need forwarding.

Top module: `fwd_unit`

## Requirements
- R1: After reset is asserted, and on every cycle until a new instruction reaches execute, all three selects are 00 (register file). A producer that was in flight when reset came never forwards afterwards.
- R2: Select encoding is 00 = register file, 10 = execute/memory, 01 = memory/write-back, and 11 never appears. A source matching the destination of the instruction one slot older (a valid writer) selects 10.
- R3: A source matching only the destination of the valid writer two slots older selects 01.
- R4: When both older writers target the same register as a source, that source selects 10, because the younger producer wins.
- R5: Register 0 is never forwarded. A producer whose destination is 0 leaves the select at 00.
- R6: A producer with its write enable low is never forwarded.
- R7: A consumer three or more slots behind its producer selects 00.
- R8: When the execute instruction uses an immediate as its second ALU input, the second ALU select is 00.
- R9: The store-data select follows the R2 to R7 rules on the second source register when the execute instruction is a store. For any other instruction it is 00. An example is a load result two slots older feeding the store data, which gives 01.
- R10: A bubble slot (valid low) never acts as a producer and drives all three selects to 00 while it is in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| id_rs1_i | input | REG_AW | First source register of the decode instruction |
| id_rs2_i | input | REG_AW | Second source register (also store data) |
| id_rd_i | input | REG_AW | Destination register |
| id_we_i | input | 1 | Instruction writes its destination |
| id_use_imm_i | input | 1 | Second ALU input is an immediate |
| id_store_i | input | 1 | Instruction is a store |
| a_sel_o | output | 2 | Source select for the first ALU input |
| b_sel_o | output | 2 | Source select for the second ALU input |
| st_sel_o | output | 2 | Source select for the store data |

## Verification
The hardest case to reach is the register-to-register collision in which both older stages write the same register that the execute instruction reads. It only arises from two back-to-back writers followed at once by a reader. The stimulus table sets this up by writing one register in two consecutive slots and reading it twice in the next slot. Other rows put a bubble directly after a load, and a store right behind that bubble. This checks that an invalid slot does not forward, while the load two slots ahead still feeds the store data.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_MEMWB = 2'b01,
    SEL_EXMEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_OPS    = 3;
  localparam int unsigned OP_ALU_A   = 0;
  localparam int unsigned OP_ALU_B   = 1;
  localparam int unsigned OP_ST_DATA = 2;
endpackage

// File: rtl/fwd_ex_reg.sv
module fwd_ex_reg #(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] id_rd_i,
  input  logic              id_we_i,
  input  logic              id_use_imm_i,
  input  logic              id_store_i,
  output logic              ex_valid_o,
  output logic [REG_AW-1:0] ex_rs1_o,
  output logic [REG_AW-1:0] ex_rs2_o,
  output logic              ex_use_imm_o,
  output logic              ex_store_o,
  output logic              ex_wr_o,
  output logic [REG_AW-1:0] ex_rd_o
);
  logic id_wr;
  // a writer only counts when the slot is real and the target is not r0
  assign id_wr = id_valid_i && id_we_i && (id_rd_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_valid_o   <= 1'b0;
      ex_rs1_o     <= '0;
      ex_rs2_o     <= '0;
      ex_use_imm_o <= 1'b0;
      ex_store_o   <= 1'b0;
      ex_wr_o      <= 1'b0;
      ex_rd_o      <= '0;
    end else begin
      ex_valid_o   <= id_valid_i;
      ex_rs1_o     <= id_rs1_i;
      ex_rs2_o     <= id_rs2_i;
      ex_use_imm_o <= id_use_imm_i;
      ex_store_o   <= id_store_i;
      ex_wr_o      <= id_wr;
      ex_rd_o      <= id_rd_i;
    end
  end
endmodule

// File: rtl/fwd_dest_pipe.sv
module fwd_dest_pipe #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_wr_i,
  input  logic [REG_AW-1:0]            in_rd_i,
  output logic [DEPTH-1:0]             wr_o,
  output logic [DEPTH-1:0][REG_AW-1:0] rd_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              nxt_wr;
    logic [REG_AW-1:0] nxt_rd;
    if (s == 0) begin : g_head
      assign nxt_wr = in_wr_i;
      assign nxt_rd = in_rd_i;
    end else begin : g_body
      assign nxt_wr = wr_o[s-1];
      assign nxt_rd = rd_o[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_o[s] <= 1'b0;
        rd_o[s] <= '0;
      end else begin
        wr_o[s] <= nxt_wr;
        rd_o[s] <= nxt_rd;
      end
    end
  end
endmodule

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              use_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic              near_wr_i,
  input  logic [REG_AW-1:0] near_rd_i,
  input  logic              far_wr_i,
  input  logic [REG_AW-1:0] far_rd_i,
  output fwd_sel_e          sel_o
);
  logic hit_near, hit_far;
  assign hit_near = use_i && near_wr_i && (near_rd_i == src_i);
  assign hit_far  = use_i && far_wr_i  && (far_rd_i  == src_i);

  // younger producer first
  always_comb begin
    if (hit_near)     sel_o = SEL_EXMEM;
    else if (hit_far) sel_o = SEL_MEMWB;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic [REG_AW-1:0] id_rd_i,
  input  logic              id_we_i,
  input  logic              id_use_imm_i,
  input  logic              id_store_i,
  output logic [1:0]        a_sel_o,
  output logic [1:0]        b_sel_o,
  output logic [1:0]        st_sel_o
);
  localparam int unsigned PROD_STAGES = 2;
  localparam int unsigned ST_EXMEM    = 0;
  localparam int unsigned ST_MEMWB    = 1;

  logic              ex_valid, ex_use_imm, ex_store, ex_wr;
  logic [REG_AW-1:0] ex_rs1, ex_rs2, ex_rd;

  logic [PROD_STAGES-1:0]             prod_wr;
  logic [PROD_STAGES-1:0][REG_AW-1:0] prod_rd;

  logic [NUM_OPS-1:0]             op_use;
  logic [NUM_OPS-1:0][REG_AW-1:0] op_src;
  fwd_sel_e                       op_sel [NUM_OPS];

  fwd_ex_reg #(.REG_AW(REG_AW)) u_ex_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .id_valid_i   (id_valid_i),
    .id_rs1_i     (id_rs1_i),
    .id_rs2_i     (id_rs2_i),
    .id_rd_i      (id_rd_i),
    .id_we_i      (id_we_i),
    .id_use_imm_i (id_use_imm_i),
    .id_store_i   (id_store_i),
    .ex_valid_o   (ex_valid),
    .ex_rs1_o     (ex_rs1),
    .ex_rs2_o     (ex_rs2),
    .ex_use_imm_o (ex_use_imm),
    .ex_store_o   (ex_store),
    .ex_wr_o      (ex_wr),
    .ex_rd_o      (ex_rd)
  );

  fwd_dest_pipe #(.REG_AW(REG_AW), .DEPTH(PROD_STAGES)) u_dest_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_wr_i (ex_wr),
    .in_rd_i (ex_rd),
    .wr_o    (prod_wr),
    .rd_o    (prod_rd)
  );

  // operand consumers in execute
  assign op_use[OP_ALU_A]   = ex_valid;
  assign op_src[OP_ALU_A]   = ex_rs1;
  assign op_use[OP_ALU_B]   = ex_valid && !ex_use_imm;
  assign op_src[OP_ALU_B]   = ex_rs2;
  assign op_use[OP_ST_DATA] = ex_valid && ex_store;
  assign op_src[OP_ST_DATA] = ex_rs2;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    fwd_match #(.REG_AW(REG_AW)) u_match (
      .use_i     (op_use[i]),
      .src_i     (op_src[i]),
      .near_wr_i (prod_wr[ST_EXMEM]),
      .near_rd_i (prod_rd[ST_EXMEM]),
      .far_wr_i  (prod_wr[ST_MEMWB]),
      .far_rd_i  (prod_rd[ST_MEMWB]),
      .sel_o     (op_sel[i])
    );
  end

  assign a_sel_o  = op_sel[OP_ALU_A];
  assign b_sel_o  = op_sel[OP_ALU_B];
  assign st_sel_o = op_sel[OP_ST_DATA];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              id_valid_i,
  input logic [REG_AW-1:0] id_rs1_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic [REG_AW-1:0] id_rd_i,
  input logic              id_we_i,
  input logic              id_use_imm_i,
  input logic              id_store_i,
  input logic [1:0]        a_sel_o,
  input logic [1:0]        b_sel_o,
  input logic [1:0]        st_sel_o
);
  logic [1:0] warm_cnt;
  logic       warm;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd3);

  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_sel_o != 2'b11) && (b_sel_o != 2'b11) && (st_sel_o != 2'b11)); // R2

  AST_A_NEAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && a_sel_o == 2'b10) |-> ($past(id_rs1_i) == $past(id_rd_i, 2) &&
      $past(id_we_i, 2) && $past(id_valid_i, 2) && $past(id_rd_i, 2) != '0)); // R2

  AST_A_FAR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && a_sel_o == 2'b01) |-> ($past(id_rs1_i) == $past(id_rd_i, 3) &&
      $past(id_we_i, 3) && $past(id_valid_i, 3) && $past(id_rd_i, 3) != '0)); // R3

  AST_A_NEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(id_valid_i) && $past(id_valid_i, 2) && $past(id_we_i, 2) &&
      $past(id_rd_i, 2) != '0 && $past(id_rs1_i) == $past(id_rd_i, 2))
      |-> a_sel_o == 2'b10); // R4

  AST_R0_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(id_rs1_i) == '0) |-> a_sel_o == 2'b00); // R5

  AST_B_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(id_valid_i) && $past(id_use_imm_i)) |-> b_sel_o == 2'b00); // R8

  AST_ST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(id_valid_i) && !$past(id_store_i)) |-> st_sel_o == 2'b00); // R9

  AST_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(id_valid_i)) |->
      (a_sel_o == 2'b00 && b_sel_o == 2'b00 && st_sel_o == 2'b00)); // R10
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .id_valid_i   (id_valid_i),
  .id_rs1_i     (id_rs1_i),
  .id_rs2_i     (id_rs2_i),
  .id_rd_i      (id_rd_i),
  .id_we_i      (id_we_i),
  .id_use_imm_i (id_use_imm_i),
  .id_store_i   (id_store_i),
  .a_sel_o      (a_sel_o),
  .b_sel_o      (b_sel_o),
  .st_sel_o     (st_sel_o)
);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;
  localparam int unsigned AW     = 5;
  localparam int unsigned NVEC   = 18;
  localparam int unsigned WD_CYC = 2000;

  typedef struct packed {
    logic          v;
    logic [AW-1:0] rd;
    logic          we;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          imm;
    logic          st;
    logic [1:0]    ea;
    logic [1:0]    eb;
    logic [1:0]    es;
  } vec_t;

  // each row is checked one cycle after it is driven (then in execute)
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'd1,  1'b1, 5'd2,  5'd3,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd4,  1'b1, 5'd5,  5'd1,  1'b0, 1'b0, 2'b00, 2'b10, 2'b00},
    '{1'b1, 5'd6,  1'b1, 5'd1,  5'd7,  1'b0, 1'b0, 2'b01, 2'b00, 2'b00},
    '{1'b1, 5'd8,  1'b1, 5'd1,  5'd9,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd10, 1'b1, 5'd1,  5'd11, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd12, 1'b1, 5'd13, 5'd14, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd12, 1'b1, 5'd15, 5'd16, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd17, 1'b1, 5'd12, 5'd12, 1'b0, 1'b0, 2'b10, 2'b10, 2'b00},
    '{1'b1, 5'd0,  1'b1, 5'd1,  5'd2,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd18, 1'b1, 5'd0,  5'd0,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd5,  1'b0, 5'd18, 5'd17, 1'b1, 1'b1, 2'b10, 2'b00, 2'b00},
    '{1'b1, 5'd19, 1'b1, 5'd5,  5'd5,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd20, 1'b1, 5'd19, 5'd0,  1'b1, 1'b0, 2'b10, 2'b00, 2'b00},
    '{1'b0, 5'd20, 1'b1, 5'd20, 5'd20, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd0,  1'b0, 5'd21, 5'd20, 1'b1, 1'b1, 2'b00, 2'b00, 2'b01},
    '{1'b1, 5'd23, 1'b1, 5'd3,  5'd3,  1'b0, 1'b0, 2'b00, 2'b00, 2'b00},
    '{1'b1, 5'd0,  1'b0, 5'd0,  5'd23, 1'b1, 1'b1, 2'b00, 2'b00, 2'b10},
    '{1'b1, 5'd24, 1'b1, 5'd23, 5'd1,  1'b0, 1'b0, 2'b01, 2'b00, 2'b00}
  };

  string vec_req [NVEC] = '{"R1", "R2", "R3", "R7", "R7", "R7", "R7", "R4", "R2",
                            "R5", "R8", "R6", "R8", "R10", "R9", "R2", "R9", "R9"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          v = 1'b0, we = 1'b0, imm = 1'b0, st = 1'b0;
  logic [AW-1:0] rs1 = '0, rs2 = '0, rd = '0;
  logic [1:0]    a_sel, b_sel, st_sel;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fwd_unit #(.REG_AW(AW)) u_fwd_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .id_valid_i   (v),
    .id_rs1_i     (rs1),
    .id_rs2_i     (rs2),
    .id_rd_i      (rd),
    .id_we_i      (we),
    .id_use_imm_i (imm),
    .id_store_i   (st),
    .a_sel_o      (a_sel),
    .b_sel_o      (b_sel),
    .st_sel_o     (st_sel)
  );

  task automatic chk(input string req, input string what, input logic [1:0] act,
                     input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [1:0] ea, input logic [1:0] eb,
                         input logic [1:0] es);
    chk(req, "a_sel", a_sel, ea);
    chk(req, "b_sel", b_sel, eb);
    chk(req, "st_sel", st_sel, es);
  endtask

  task automatic drive(input vec_t x);
    v = x.v; rd = x.rd; we = x.we; rs1 = x.rs1; rs2 = x.rs2; imm = x.imm; st = x.st;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1", 2'b00, 2'b00, 2'b00);   // reset state
    rst_n = 1'b1;

    drive(VEC[0]);
    for (int k = 1; k < NVEC; k++) begin
      @(negedge clk);
      chk_all(vec_req[k-1], VEC[k-1].ea, VEC[k-1].eb, VEC[k-1].es);
      drive(VEC[k]);
    end
    @(negedge clk);
    chk_all(vec_req[NVEC-1], VEC[NVEC-1].ea, VEC[NVEC-1].eb, VEC[NVEC-1].es);

    // R1: producer of r1 in flight when reset hits, reader afterwards
    drive('{1'b1, 5'd1, 1'b1, 5'd1, 5'd1, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00});
    @(negedge clk);
    v = 1'b0;
    rst_n = 1'b0;
    #1;
    chk_all("R1", 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1'b1, 5'd2, 1'b1, 5'd1, 5'd1, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00});
    @(negedge clk);
    chk_all("R1", 2'b00, 2'b00, 2'b00);

    // R6 with register match at distance two: non-writer two slots ahead
    drive('{1'b1, 5'd9, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00});
    @(negedge clk);
    drive('{1'b0, 5'd0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 2'b00, 2'b00, 2'b00});
    @(negedge clk);
    drive('{1'b1, 5'd3, 1'b1, 5'd9, 5'd9, 1'b0, 1'b1, 2'b00, 2'b00, 2'b00});
    @(negedge clk);
    chk_all("R6", 2'b00, 2'b00, 2'b00);

    finish_run();
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule